// File: doc/BRIEF.md
# External Interrupt Line Controller

The block watches a parameterised set of external interrupt inputs, from one to thirty-two. Each input passes through a two-stage synchronizer into the system clock domain. A detector then looks for the condition that the line's own configuration word selects. That condition can be a low level, a high level, a rising transition, a falling transition or either transition. A detected condition is held in a latched status bit, which software clears by writing a one. A request leaves the block on the line's own output for as long as that status bit is set and the line is enabled.

Software reaches the block through a plain 32-bit register port, using one-cycle write and read strobes and a byte address. Enables are never written as a whole mask. One register turns lines on with ones, another turns lines off with ones, and a zero bit in either register has no effect. A monitor register shows the synchronized level of every input, and the request register shows which lines are asking for service.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every enable bit, every latched detect bit, every configuration word, the read data and every request output are zero.
- R2: A write to offset 0x08 sets each enable bit whose data bit is 1. A write to offset 0x04 clears each enable bit whose data bit is 1. Data bits of 0 leave the enable unchanged. A read of either offset returns the enable mask.
- R3: Sense code 0x01 detects a low level and sense code 0x02 detects a high level. While the active level persists, the detect bit is set again on every cycle, so a clear written at that time has no lasting effect.
- R4: Sense code 0x08 detects a rising edge, 0x04 detects a falling edge and 0x0C detects either edge. The detect bit stays set after the input has gone back.
- R5: An input change reaches the detect bit on the third rising clock edge after it is applied. The edges are counted from the first edge at which the input is sampled.
- R6: Writing 1 to a bit at offset 0x100 clears that line's detect bit. If a detection occurs in the same cycle as the clear, the bit stays set.
- R7: A read of offset 0x104 returns the synchronized level of each input, one bit per line.
- R8: Bit n of the read at offset 0x00, and the request output for line n, are both 1 exactly when line n is detected and enabled. Reading offset 0x100 returns the detect bits whether or not the lines are enabled.
- R9: Any sense code other than 0x01, 0x02, 0x04, 0x08 or 0x0C disables detection for that line.
- R10: Offsets not listed here read as zero, and writes to them change nothing. This includes misaligned addresses and configuration slots at or above the line count.
- R11: Read data is registered. It takes the value addressed on the clock edge at which the read strobe is high, and it holds that value until the next read.
- R12: Line n's configuration word is at offset 0x180 + 4*n. Only bits 5:0 are stored, and a read returns them with the upper bits as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_irq_i | input | NUM_LINES | Raw external interrupt inputs |
| bus_wr_i | input | 1 | One-cycle write strobe |
| bus_rd_i | input | 1 | One-cycle read strobe |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_LINES | Per-line request: detected and enabled |

## Verification
A corrupted detect or enable bit appears directly on `irq_o` from the cycle after the faulty update. The bench compares that output with its own model at every clock, so such an error is caught within one cycle. A fault in the synchronizer stage or in the previous-level flop shifts or drops an edge detection. That shows up on the request output one or two cycles away from the cycle the model predicts. Errors in address decode or in the configuration store surface only on a later read or detection, so every read result is also compared on the cycle after its strobe.

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
package extint_pkg;

  // Register byte offsets
  localparam int unsigned OFS_REQ   = 'h000;
  localparam int unsigned OFS_ENCLR = 'h004;
  localparam int unsigned OFS_ENSET = 'h008;
  localparam int unsigned OFS_DET   = 'h100;
  localparam int unsigned OFS_MON   = 'h104;
  localparam int unsigned OFS_CFG   = 'h180;

  localparam int unsigned SENSE_W   = 6;
  localparam int unsigned DATA_W    = 32;

  // Sense codes held in bits 5:0 of each configuration word
  typedef enum logic [SENSE_W-1:0] {
    SNS_OFF  = 6'h00,
    SNS_LOW  = 6'h01,
    SNS_HIGH = 6'h02,
    SNS_FALL = 6'h04,
    SNS_RISE = 6'h08,
    SNS_BOTH = 6'h0C
  } sense_e;

endpackage

// File: rtl/extint_rst_sync.sv
`timescale 1ns/1ps
module extint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/extint_sync.sv
`timescale 1ns/1ps
module extint_sync #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] raw_i,
  output logic [NUM_LINES-1:0] lvl_o
);
  logic [NUM_LINES-1:0] meta_q;
  logic [NUM_LINES-1:0] lvl_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic meta_d;
    logic lvl_d;
    always_comb begin
      meta_d = raw_i[g];
      lvl_d  = meta_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        lvl_q[g]  <= 1'b0;
      end else begin
        meta_q[g] <= meta_d;
        lvl_q[g]  <= lvl_d;
      end
    end
  end

  assign lvl_o = lvl_q;

  // Warm-up counter so the two-deep check never looks back into reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R5: the level seen by the detector is the raw input two edges earlier
  a_r5_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (lvl_o == $past(raw_i, 2)));
endmodule

// File: rtl/extint_detect.sv
`timescale 1ns/1ps
module extint_detect
  import extint_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_LINES-1:0]             lvl_i,
  input  logic [NUM_LINES-1:0][SENSE_W-1:0] cfg_i,
  output logic [NUM_LINES-1:0]             event_o
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] prev_d;

  always_comb prev_d = lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic rise, fall;
    always_comb begin
      rise = lvl_i[g] & ~prev_q[g];
      fall = ~lvl_i[g] & prev_q[g];
      case (sense_e'(cfg_i[g]))
        SNS_LOW:  event_o[g] = ~lvl_i[g];
        SNS_HIGH: event_o[g] = lvl_i[g];
        SNS_FALL: event_o[g] = fall;
        SNS_RISE: event_o[g] = rise;
        SNS_BOTH: event_o[g] = rise | fall;
        default:  event_o[g] = 1'b0;
      endcase
    end
  end

  // R4: an edge event is only possible when the level actually moved
  a_r4_edge_moved: assert property (@(posedge clk) disable iff (!rst_n)
    ((event_o & ~{NUM_LINES{1'b0}}) != '0) |->
      ((event_o & ~(lvl_i ^ prev_q) & ~lvl_level_mask(cfg_i)) == '0));

  function automatic logic [NUM_LINES-1:0] lvl_level_mask(
      input logic [NUM_LINES-1:0][SENSE_W-1:0] c);
    logic [NUM_LINES-1:0] m;
    for (int i = 0; i < NUM_LINES; i++)
      m[i] = (c[i] == SNS_LOW) || (c[i] == SNS_HIGH);
    return m;
  endfunction
endmodule

// File: rtl/extint_regs.sv
`timescale 1ns/1ps
module extint_regs
  import extint_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 9
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_i,
  input  logic                              rd_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic [NUM_LINES-1:0]              event_i,
  input  logic [NUM_LINES-1:0]              lvl_i,
  output logic [NUM_LINES-1:0][SENSE_W-1:0] cfg_o,
  output logic [NUM_LINES-1:0]              irq_o,
  output logic [DATA_W-1:0]                 rdata_o
);
  localparam logic [ADDR_W-1:0] A_REQ   = ADDR_W'(OFS_REQ);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFS_ENCLR);
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFS_ENSET);
  localparam logic [ADDR_W-1:0] A_DET   = ADDR_W'(OFS_DET);
  localparam logic [ADDR_W-1:0] A_MON   = ADDR_W'(OFS_MON);

  logic [NUM_LINES-1:0]              en_q, en_d;
  logic [NUM_LINES-1:0]              det_q, det_d;
  logic [NUM_LINES-1:0][SENSE_W-1:0] cfg_q, cfg_d;
  logic [DATA_W-1:0]                 rdata_q, rdata_d;
  logic [NUM_LINES-1:0]              cfg_sel;
  logic                              hit;
  logic [NUM_LINES-1:0]              wmask;

  // Address decode
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sel
    assign cfg_sel[g] = (addr_i == ADDR_W'(OFS_CFG + 4 * g));
  end

  always_comb begin
    wmask = wdata_i[NUM_LINES-1:0];
    hit = (addr_i == A_REQ) || (addr_i == A_ENCLR) || (addr_i == A_ENSET) ||
          (addr_i == A_DET) || (addr_i == A_MON)   || (|cfg_sel);
  end

  // Next state
  always_comb begin
    en_d = en_q;
    if (wr_i && addr_i == A_ENSET) en_d = en_q | wmask;
    if (wr_i && addr_i == A_ENCLR) en_d = en_q & ~wmask;
  end

  always_comb begin
    det_d = det_q;
    if (wr_i && addr_i == A_DET) det_d = det_q & ~wmask;
    det_d = det_d | event_i;
  end

  always_comb begin
    cfg_d = cfg_q;
    for (int i = 0; i < NUM_LINES; i++)
      if (wr_i && cfg_sel[i]) cfg_d[i] = wdata_i[SENSE_W-1:0];
  end

  always_comb begin
    rdata_d = '0;
    if (addr_i == A_REQ)   rdata_d[NUM_LINES-1:0] = det_q & en_q;
    if (addr_i == A_ENCLR) rdata_d[NUM_LINES-1:0] = en_q;
    if (addr_i == A_ENSET) rdata_d[NUM_LINES-1:0] = en_q;
    if (addr_i == A_DET)   rdata_d[NUM_LINES-1:0] = det_q;
    if (addr_i == A_MON)   rdata_d[NUM_LINES-1:0] = lvl_i;
    for (int i = 0; i < NUM_LINES; i++)
      if (cfg_sel[i]) rdata_d[SENSE_W-1:0] = cfg_q[i];
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      det_q <= '0;
      cfg_q <= '0;
    end else begin
      if (wr_i) en_q  <= en_d;
      det_q <= det_d;
      if (wr_i) cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign cfg_o   = cfg_q;
  assign irq_o   = det_q & en_q;
  assign rdata_o = rdata_q;

  // R2: ones written to the set register land in the mask
  a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_ENSET) |=> ((en_q & $past(wmask)) == $past(wmask)));
  // R2: ones written to the clear register leave the mask
  a_r2_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_ENCLR) |=> ((en_q & $past(wmask)) == '0));
  // R6: a detection always survives into the latched status
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (event_i != '0) |=> ((det_q & $past(event_i)) == $past(event_i)));
  // R6: cleared bits without a concurrent event are gone
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == A_DET) |=> ((det_q & $past(wmask & ~event_i)) == '0));
  // R7: monitor read returns the synchronized level
  a_r7_monitor: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == A_MON) |=> (rdata_o[NUM_LINES-1:0] == $past(lvl_i)));
  // R10: unmapped writes touch nothing
  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !hit) |=> ($stable(en_q) && $stable(cfg_q)));
  // R11: read data holds between reads
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/extint_ctrl.sv
`timescale 1ns/1ps
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ext_irq_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic                              rst_int_n;
  logic [NUM_LINES-1:0]              lvl;
  logic [NUM_LINES-1:0]              evt;
  logic [NUM_LINES-1:0][SENSE_W-1:0] cfg;

  initial begin
    a_param_lines: assert (NUM_LINES >= 1 && NUM_LINES <= 32);
    a_param_addr:  assert (ADDR_W >= 9);
  end

  extint_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_int_n)
  );

  extint_sync #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .raw_i (ext_irq_i),
    .lvl_o (lvl)
  );

  extint_detect #(.NUM_LINES(NUM_LINES)) u_det (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lvl_i   (lvl),
    .cfg_i   (cfg),
    .event_o (evt)
  );

  extint_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .event_i (evt),
    .lvl_i   (lvl),
    .cfg_o   (cfg),
    .irq_o   (irq_o),
    .rdata_o (bus_rdata_o)
  );

  // R8: a request is never raised for a line that was just disabled
  a_r8_disable: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr_i && bus_addr_i == ADDR_W'(OFS_ENCLR)) |=>
      ((irq_o & $past(bus_wdata_i[NUM_LINES-1:0])) == '0));
endmodule

// File: tb/extint_ctrl_tb_top.sv
`timescale 1ns/1ps
module extint_ctrl_tb_top;
  localparam int N  = 8;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  ext;
  logic          wr, rd;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [N-1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  extint_ctrl #(.NUM_LINES(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [N-1:0] m_s1, m_s2, m_pv, m_det, m_en;
  logic [N-1:0] o_s1, o_s2, o_pv, o_det, o_en, clr;
  logic [5:0]   m_cfg [N];
  logic [5:0]   o_cfg [N];
  logic [31:0]  m_rd;
  logic         m_r1, m_r2, o_r2;

  function automatic logic [31:0] mread(input logic [AW-1:0] a);
    logic [31:0] v = 0;
    if (a == 9'h000) v[N-1:0] = o_det & o_en;
    if (a == 9'h004 || a == 9'h008) v[N-1:0] = o_en;
    if (a == 9'h100) v[N-1:0] = o_det;
    if (a == 9'h104) v[N-1:0] = o_s2;
    for (int i = 0; i < N; i++)
      if (a == AW'(9'h180 + 4 * i)) v[5:0] = o_cfg[i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_s1 = 0; m_s2 = 0; m_pv = 0; m_det = 0; m_en = 0;
      m_rd = 0;
      for (int i = 0; i < N; i++) m_cfg[i] = 0;
    end else begin
      o_s1 = m_s1; o_s2 = m_s2; o_pv = m_pv; o_det = m_det; o_en = m_en;
      o_r2 = m_r2;
      for (int i = 0; i < N; i++) o_cfg[i] = m_cfg[i];
      m_r2 = m_r1; m_r1 = 1;
      if (o_r2) begin
        m_s1 = ext; m_s2 = o_s1; m_pv = o_s2;
        clr = (wr && addr == 9'h100) ? wdata[N-1:0] : '0;
        for (int i = 0; i < N; i++) begin
          bit ev;
          case (o_cfg[i])
            6'h01:   ev = !o_s2[i];
            6'h02:   ev = o_s2[i];
            6'h04:   ev = !o_s2[i] && o_pv[i];
            6'h08:   ev = o_s2[i] && !o_pv[i];
            6'h0C:   ev = o_s2[i] != o_pv[i];
            default: ev = 0;
          endcase
          m_det[i] = ev || (o_det[i] && !clr[i]);
          if (wr && addr == AW'(9'h180 + 4 * i)) m_cfg[i] = wdata[5:0];
        end
        if (wr && addr == 9'h008) m_en = o_en | wdata[N-1:0];
        if (wr && addr == 9'h004) m_en = o_en & ~wdata[N-1:0];
        if (rd) m_rd = mread(addr);
      end
    end
  end

  // Every-cycle comparison (R8 request outputs, R11 read data)
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (irq !== (m_det & m_en)) begin
        errors++;
        $display("FAIL R8 irq_o actual %h expected %h at %0t", irq, m_det & m_en, $time);
      end
      checks++;
      if (rdata !== m_rd) begin
        errors++;
        $display("FAIL R11 rdata actual %h expected %h at %0t", rdata, m_rd, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; addr = '0; wdata = '0;
  endtask

  task automatic bus_read(input string tag, input logic [AW-1:0] a,
                          input logic [31:0] mask, input logic [31:0] exp);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; addr = '0;
    chk(tag, rdata & mask, exp);
  endtask

  task automatic set_line(input int i, input logic v);
    @(negedge clk); ext[i] = v;
  endtask

  initial begin
    rst_n = 0; ext = '0; wr = 0; rd = 0; addr = '0; wdata = '0;
    idle(2); cmp_on = 1;
    idle(2); rst_n = 1;
    idle(4);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    bus_read("R1 req",  9'h000, 32'hFFFF_FFFF, 0);
    bus_read("R1 en",   9'h004, 32'hFFFF_FFFF, 0);
    bus_read("R1 cfg0", 9'h180, 32'hFFFF_FFFF, 0);

    // R12 configuration
    bus_write(9'h180, 32'h08);
    bus_write(9'h184, 32'h04);
    bus_write(9'h188, 32'h0C);
    bus_write(9'h18C, 32'h02);
    bus_write(9'h190, 32'h01);
    bus_write(9'h194, 32'h03);
    bus_write(9'h19C, 32'hFFFF_FF48);
    bus_read("R12 cfg7 masked", 9'h19C, 32'hFFFF_FFFF, 32'h08);
    bus_read("R12 cfg5", 9'h194, 32'hFFFF_FFFF, 32'h03);

    // R2 enables
    bus_write(9'h008, 32'hFF);
    bus_read("R2 set", 9'h004, 32'hFFFF_FFFF, 32'hFF);
    bus_write(9'h004, 32'h00);
    bus_read("R2 clear zero no effect", 9'h004, 32'hFFFF_FFFF, 32'hFF);
    bus_write(9'h008, 32'h00);
    bus_read("R2 set zero no effect", 9'h008, 32'hFFFF_FFFF, 32'hFF);

    // R3 low-level line re-sets after clear
    idle(3);
    bus_write(9'h100, 32'hFF);
    bus_read("R3 low level persists", 9'h100, 32'hFF, 32'h10);

    // R5 latency on rising line 0
    set_line(0, 1);
    @(negedge clk); chk("R5 edge1", 32'(irq[0]), 0);
    @(negedge clk); chk("R5 edge2", 32'(irq[0]), 0);
    @(negedge clk); chk("R5 edge3", 32'(irq[0]), 1);

    // R4 both edges on line 2, R6 clear
    set_line(2, 1); idle(4); chk("R4 both rise", 32'(irq[2]), 1);
    bus_write(9'h100, 32'h04); idle(1); chk("R6 clear", 32'(irq[2]), 0);
    set_line(2, 0); idle(4); chk("R4 both fall", 32'(irq[2]), 1);

    // R4 falling line 1
    set_line(1, 1); idle(4); chk("R4 fall ignores rise", 32'(irq[1]), 0);
    set_line(1, 0); idle(4); chk("R4 fall", 32'(irq[1]), 1);

    // R3 high level line 3
    set_line(3, 1); idle(4); chk("R3 high", 32'(irq[3]), 1);
    bus_write(9'h100, 32'h08); idle(2); chk("R3 clear while active", 32'(irq[3]), 1);
    set_line(3, 0); idle(4);
    bus_write(9'h100, 32'h08); idle(1); chk("R3 clear after release", 32'(irq[3]), 0);

    // R3 low level line 4 released
    set_line(4, 1); idle(4);
    bus_write(9'h100, 32'h10); idle(1); chk("R3 low released", 32'(irq[4]), 0);

    // R9 invalid and empty sense codes
    set_line(5, 1); idle(4); set_line(5, 0); idle(4);
    chk("R9 bad code", 32'(irq[5]), 0);
    set_line(6, 1); idle(4); set_line(6, 0); idle(4);
    bus_read("R9 det bits", 9'h100, 32'h60, 0);

    // R6 clear in the same cycle as a new rising edge
    bus_write(9'h100, 32'h01); idle(1); chk("R6 pre-clear", 32'(irq[0]), 0);
    set_line(0, 0); idle(4);
    set_line(0, 1);
    @(negedge clk);
    bus_write(9'h100, 32'h01);
    chk("R6 event wins", 32'(irq[0]), 1);

    // R7 monitor
    @(negedge clk); ext = 8'hA5; idle(3);
    bus_read("R7 monitor", 9'h104, 32'hFFFF_FFFF, 32'hA5);

    // R8 request gating
    bus_write(9'h004, 32'h01); idle(1);
    chk("R8 disabled", 32'(irq[0]), 0);
    bus_read("R8 req bit", 9'h000, 32'h01, 0);
    bus_read("R8 det bit", 9'h100, 32'h01, 1);
    bus_write(9'h008, 32'h01); idle(1);
    chk("R8 re-enabled", 32'(irq[0]), 1);

    // R10 unmapped
    bus_write(9'h00C, 32'hFFFF_FFFF);
    bus_write(9'h1A0, 32'h02);
    bus_write(9'h181, 32'h0C);
    bus_read("R10 rd 0x00C", 9'h00C, 32'hFFFF_FFFF, 0);
    bus_read("R10 rd 0x1A0", 9'h1A0, 32'hFFFF_FFFF, 0);
    bus_read("R10 rd 0x181", 9'h181, 32'hFFFF_FFFF, 0);
    bus_read("R10 en kept",  9'h004, 32'hFFFF_FFFF, 32'hFF);
    bus_read("R10 cfg0 kept", 9'h180, 32'hFFFF_FFFF, 32'h08);

    // R11 hold
    bus_read("R11 read", 9'h188, 32'hFFFF_FFFF, 32'h0C);
    idle(5);
    chk("R11 hold", rdata, 32'h0C);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule